// File: doc/BRIEF.md
# Block-Protected I2C Configuration EEPROM

This block is a slave on a two-wire serial bus that exposes a 512-byte configuration store. The store is split into four 128-byte blocks. A protect latch can lock the three lowest blocks against writes, and a software command over the same bus sets or clears that latch. The top block, bytes 384 to 511, stays writable at all times. The bus pins are sampled by the system clock, so SCL and SDA are oversampled. The block drives SDA only by pulling it low (`sda_oe`).

A frame opens with a START and a device byte. Bits 7:4 of that byte select the target: `1010` is the storage and `0110` is the protect latch. Bits 3:1 must equal `sel_i`, and bit 0 gives the direction (1 = read). A storage write sends two address bytes after the device byte. Bit 0 of the first address byte is address bit 8, and the second address byte carries bits 7:0. Data bytes follow. A random read is a storage write frame that carries only the address, then a repeated START and a read device byte. A read frame with no address phase continues from the current pointer. After a STOP that ends a frame which changed the array or the latch, the block stays busy for `BUSY_CYC` clock cycles.

Top module: `cfg_eeprom_i2c`

## Requirements
- R1: The block acknowledges a device byte only when bits 3:1 equal `sel_i` and bits 7:4 are `1010` (storage) or `0110` (protect latch). Any other device byte gets a NACK, and the block then stays off the bus until the next START.
- R2: A storage write frame sets the 9-bit pointer from its two address bytes. Each data byte that follows is stored at the pointer. A random read returns the stored bytes.
- R3: The pointer advances by one after every data byte written or read, and it wraps from 511 to 0. This applies to multi-byte writes and to sequential reads.
- R4: A read frame without an address phase starts at the pointer value left by the previous access.
- R5: A write to the protect latch with byte 0x5A sets the latch, and 0xA5 clears it. Any other byte is acknowledged and has no effect. Reading the latch returns 0x01 when it is set and 0x00 when it is clear.
- R6: While the latch is set, a data byte aimed at addresses 0 to 383 is acknowledged, but the array is left unchanged.
- R7: Addresses 384 to 511 accept data whether the latch is set or clear.
- R8: A STOP that ends a frame which stored a byte or changed the latch starts a busy period of `BUSY_CYC` cycles. During that period the block answers NACK to its device byte, and it acknowledges again once the period is over.
- R9: If SCL stays low for `TMO_CYC` cycles during a frame, the block releases SDA and returns to idle. The next frame then works normally.
- R10: A START that arrives within `FREE_CYC` cycles after a STOP is ignored. The device byte that follows gets no acknowledge.
- R11: After reset, the block does not drive SDA and the protect latch is clear.
- R12: The block starts pulling SDA low only while SCL is low. After the master NACKs a read byte, the block leaves SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired bus value) |
| sel_i | input | 3 | Slave address select, matched against device byte bits 3:1 |
| sda_oe | output | 1 | High pulls SDA low (acknowledge or a 0 data bit) |

## Verification
A wrong pointer shows up as the wrong byte on the very next read. A wrap error shows up only on the byte that follows address 511. A stale or stuck protect latch shows up as a byte that reads back changed, or a latch readback of the wrong value, in the first read after the busy period. A wrong busy counter or a wrong bus-free window flips a single acknowledge bit on the next device byte. A missed timeout leaves SDA held low until the master gives up, which is visible at the line within `TMO_CYC` cycles of the stall.

// File: rtl/eep_pkg.sv
package eep_pkg;

  typedef enum logic [2:0] {
    LS_IDLE,
    LS_RX,
    LS_ACK,
    LS_TX,
    LS_MACK
  } link_st_t;

  typedef enum logic [2:0] {
    BK_DEV,
    BK_AHI,
    BK_ALO,
    BK_DATA,
    BK_PCMD
  } byte_kind_t;

  localparam logic [3:0] MEM_TYPE      = 4'b1010;
  localparam logic [3:0] PROT_TYPE     = 4'b0110;
  localparam logic [7:0] PROT_SET_CODE = 8'h5A;
  localparam logic [7:0] PROT_CLR_CODE = 8'hA5;

endpackage

// File: rtl/eep_sense.sv
module eep_sense #(
  parameter int TMO_CYC  = 3000000,
  parameter int FREE_CYC = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic active_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o,
  output logic tmo_o
);

  localparam int TW = $clog2(TMO_CYC + 1);
  localparam int FW = $clog2(FREE_CYC + 1);

  logic [1:0]    scl_sync, sda_sync;
  logic          scl_d, sda_d;
  logic [TW-1:0] tmo_q, tmo_n;
  logic [FW-1:0] free_q, free_n;
  logic          scl_hi, start_raw, stop_raw, tmo_hit;

  assign scl_hi     = scl_sync[1];
  assign sda_o      = sda_sync[1];
  assign scl_rise_o = scl_hi & ~scl_d;
  assign scl_fall_o = ~scl_hi & scl_d;
  assign start_raw  = scl_hi & scl_d & sda_d & ~sda_sync[1];
  assign stop_raw   = scl_hi & scl_d & ~sda_d & sda_sync[1];
  assign start_o    = start_raw & (free_q == '0);
  assign stop_o     = stop_raw;

  // low-time watchdog on SCL while a frame is open
  assign tmo_hit = active_i & ~scl_hi & (tmo_q == TW'(TMO_CYC - 1));
  assign tmo_o   = tmo_hit;

  always_comb begin
    tmo_n = tmo_q;
    if (!active_i || scl_hi || tmo_hit) tmo_n = '0;
    else                                tmo_n = tmo_q + 1'b1;
  end

  always_comb begin
    free_n = free_q;
    if (stop_raw)            free_n = FW'(FREE_CYC);
    else if (free_q != '0)   free_n = free_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= 2'b11;
      sda_sync <= 2'b11;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
      tmo_q    <= '0;
      free_q   <= '0;
    end else begin
      scl_sync <= {scl_sync[0], scl_i};
      sda_sync <= {sda_sync[0], sda_i};
      scl_d    <= scl_sync[1];
      sda_d    <= sda_sync[1];
      tmo_q    <= tmo_n;
      free_q   <= free_n;
    end
  end

endmodule

// File: rtl/eep_guard.sv
module eep_guard #(
  parameter int BUSY_CYC = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic commit_i,
  output logic prot_o,
  output logic busy_o
);

  localparam int BW = $clog2(BUSY_CYC + 1);

  logic          prot_q, prot_n;
  logic [BW-1:0] busy_q, busy_n;

  assign prot_o = prot_q;
  assign busy_o = (busy_q != '0);

  always_comb begin
    prot_n = prot_q;
    if (set_i)      prot_n = 1'b1;
    else if (clr_i) prot_n = 1'b0;
  end

  always_comb begin
    busy_n = busy_q;
    if (commit_i)          busy_n = BW'(BUSY_CYC);
    else if (busy_q != '0) busy_n = busy_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_q <= 1'b0;
      busy_q <= '0;
    end else begin
      prot_q <= prot_n;
      busy_q <= busy_n;
    end
  end

endmodule

// File: rtl/eep_array.sv
module eep_array #(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) cells[addr_i] <= wdata_i;
  end

  assign rdata_o = cells[addr_i];

endmodule

// File: rtl/eep_link.sv
module eep_link
  import eep_pkg::*;
#(
  parameter int ADDR_W     = 9,
  parameter int PROT_LIMIT = 384
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              tmo_i,
  input  logic [2:0]        sel_i,
  input  logic              busy_i,
  input  logic              prot_i,
  input  logic [7:0]        rdata_i,
  output logic              sda_oe_o,
  output logic              active_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  output logic              prot_set_o,
  output logic              prot_clr_o,
  output logic              commit_o,
  output logic              dev_ack_o
);

  localparam logic [ADDR_W-1:0] LIM = ADDR_W'(PROT_LIMIT);

  link_st_t          st_q, st_n;
  byte_kind_t        kind_q, kind_n;
  logic [7:0]        sr_q, sr_n;
  logic [7:0]        tx_q, tx_n;
  logic [3:0]        cnt_q, cnt_n;
  logic [ADDR_W-1:0] ptr_q, ptr_n;
  logic              seen_q, seen_n;
  logic              rd_q, rd_n;
  logic              rdp_q, rdp_n;
  logic              stored_q, stored_n;
  logic              mack_q, mack_n;
  logic              ack;

  assign sda_oe_o    = (st_q == LS_ACK) | ((st_q == LS_TX) & ~tx_q[7]);
  assign active_o    = (st_q != LS_IDLE);
  assign mem_addr_o  = ptr_q;
  assign mem_wdata_o = sr_q;

  always_comb begin
    st_n       = st_q;
    kind_n     = kind_q;
    sr_n       = sr_q;
    tx_n       = tx_q;
    cnt_n      = cnt_q;
    ptr_n      = ptr_q;
    seen_n     = seen_q;
    rd_n       = rd_q;
    rdp_n      = rdp_q;
    stored_n   = stored_q;
    mack_n     = mack_q;
    mem_we_o   = 1'b0;
    prot_set_o = 1'b0;
    prot_clr_o = 1'b0;
    commit_o   = 1'b0;
    dev_ack_o  = 1'b0;
    ack        = 1'b0;

    if (stop_i || tmo_i) begin
      st_n     = LS_IDLE;
      commit_o = stored_q;
      stored_n = 1'b0;
    end else if (start_i) begin
      st_n   = LS_RX;
      kind_n = BK_DEV;
      cnt_n  = '0;
      seen_n = 1'b0;
    end else begin
      unique case (st_q)
        LS_IDLE: ;
        LS_RX: begin
          if (scl_rise_i && cnt_q != 4'd8) begin
            sr_n  = {sr_q[6:0], sda_i};
            cnt_n = cnt_q + 4'd1;
          end else if (scl_fall_i && cnt_q == 4'd8) begin
            unique case (kind_q)
              BK_DEV: begin
                if (sr_q[3:1] == sel_i && !busy_i) begin
                  if (sr_q[7:4] == MEM_TYPE) begin
                    ack   = 1'b1;
                    rdp_n = 1'b0;
                    tx_n  = rdata_i;
                    if (!sr_q[0]) kind_n = BK_AHI;
                  end else if (sr_q[7:4] == PROT_TYPE) begin
                    ack   = 1'b1;
                    rdp_n = 1'b1;
                    tx_n  = {7'd0, prot_i};
                    if (!sr_q[0]) kind_n = BK_PCMD;
                  end
                end
                rd_n      = sr_q[0];
                dev_ack_o = ack;
              end
              BK_AHI: begin
                ack                = 1'b1;
                ptr_n[ADDR_W-1:8]  = sr_q[ADDR_W-9:0];
                kind_n             = BK_ALO;
              end
              BK_ALO: begin
                ack         = 1'b1;
                ptr_n[7:0]  = sr_q;
                kind_n      = BK_DATA;
              end
              BK_DATA: begin
                ack   = 1'b1;
                ptr_n = ptr_q + 1'b1;
                if (!prot_i || ptr_q >= LIM) begin
                  mem_we_o = 1'b1;
                  stored_n = 1'b1;
                end
              end
              BK_PCMD: begin
                ack = 1'b1;
                if (sr_q == PROT_SET_CODE) begin
                  prot_set_o = 1'b1;
                  stored_n   = 1'b1;
                end else if (sr_q == PROT_CLR_CODE) begin
                  prot_clr_o = 1'b1;
                  stored_n   = 1'b1;
                end
              end
              default: ;
            endcase
            st_n   = ack ? LS_ACK : LS_IDLE;
            seen_n = 1'b0;
          end
        end
        LS_ACK: begin
          if (scl_rise_i) seen_n = 1'b1;
          else if (scl_fall_i && seen_q) begin
            st_n  = rd_q ? LS_TX : LS_RX;
            cnt_n = '0;
          end
        end
        LS_TX: begin
          if (scl_fall_i) begin
            tx_n  = {tx_q[6:0], 1'b0};
            cnt_n = cnt_q + 4'd1;
            if (cnt_q == 4'd7) begin
              st_n   = LS_MACK;
              seen_n = 1'b0;
              if (!rdp_q) ptr_n = ptr_q + 1'b1;
            end
          end
        end
        LS_MACK: begin
          if (scl_rise_i) begin
            mack_n = ~sda_i;
            seen_n = 1'b1;
          end else if (scl_fall_i && seen_q) begin
            if (mack_q) begin
              st_n  = LS_TX;
              cnt_n = '0;
              tx_n  = rdp_q ? {7'd0, prot_i} : rdata_i;
            end else begin
              st_n = LS_IDLE;
            end
          end
        end
        default: st_n = LS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= LS_IDLE;
      kind_q   <= BK_DEV;
      sr_q     <= '0;
      tx_q     <= '0;
      cnt_q    <= '0;
      ptr_q    <= '0;
      seen_q   <= 1'b0;
      rd_q     <= 1'b0;
      rdp_q    <= 1'b0;
      stored_q <= 1'b0;
      mack_q   <= 1'b0;
    end else begin
      st_q     <= st_n;
      kind_q   <= kind_n;
      sr_q     <= sr_n;
      tx_q     <= tx_n;
      cnt_q    <= cnt_n;
      ptr_q    <= ptr_n;
      seen_q   <= seen_n;
      rd_q     <= rd_n;
      rdp_q    <= rdp_n;
      stored_q <= stored_n;
      mack_q   <= mack_n;
    end
  end

endmodule

// File: rtl/cfg_eeprom_i2c.sv
module cfg_eeprom_i2c #(
  parameter int ADDR_W    = 9,
  parameter int BLK_COUNT = 4,
  parameter int PROT_BLKS = 3,
  parameter int BUSY_CYC  = 500000,
  parameter int TMO_CYC   = 3000000,
  parameter int FREE_CYC  = 60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] sel_i,
  output logic       sda_oe
);

  localparam int BLK_BYTES  = (1 << ADDR_W) / BLK_COUNT;
  localparam int PROT_LIMIT = PROT_BLKS * BLK_BYTES;

  logic [1:0]        rst_sync;
  logic              rst_q;
  logic              sda_s, scl_rise, scl_fall, start_ev, stop_ev, tmo_ev;
  logic              active, busy, prot_on, prot_set, prot_clr, commit, dev_ack;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0]        mem_wdata, mem_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  eep_sense #(.TMO_CYC(TMO_CYC), .FREE_CYC(FREE_CYC)) u_sense (
    .clk(clk), .rst_n(rst_q), .scl_i(scl_i), .sda_i(sda_i), .active_i(active),
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_ev), .stop_o(stop_ev), .tmo_o(tmo_ev)
  );

  eep_guard #(.BUSY_CYC(BUSY_CYC)) u_guard (
    .clk(clk), .rst_n(rst_q), .set_i(prot_set), .clr_i(prot_clr),
    .commit_i(commit), .prot_o(prot_on), .busy_o(busy)
  );

  eep_link #(.ADDR_W(ADDR_W), .PROT_LIMIT(PROT_LIMIT)) u_link (
    .clk(clk), .rst_n(rst_q), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .sda_i(sda_s), .start_i(start_ev), .stop_i(stop_ev), .tmo_i(tmo_ev),
    .sel_i(sel_i), .busy_i(busy), .prot_i(prot_on), .rdata_i(mem_rdata),
    .sda_oe_o(sda_oe), .active_o(active), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .prot_set_o(prot_set),
    .prot_clr_o(prot_clr), .commit_o(commit), .dev_ack_o(dev_ack)
  );

  eep_array #(.ADDR_W(ADDR_W)) u_array (
    .clk(clk), .we_i(mem_we), .addr_i(mem_addr), .wdata_i(mem_wdata),
    .rdata_o(mem_rdata)
  );

endmodule

// File: rtl/eep_chk.sv
module eep_chk #(
  parameter int ADDR_W     = 9,
  parameter int PROT_LIMIT = 384
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_oe,
  input logic              busy,
  input logic              dev_ack,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              prot_on,
  input logic              stop_ev,
  input logic              tmo_ev
);

  localparam logic [ADDR_W-1:0] LIM = ADDR_W'(PROT_LIMIT);

  // R8
  busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !dev_ack);

  // R8
  busy_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_ev || tmo_ev));

  // R6
  prot_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && prot_on) |-> (mem_addr >= LIM));

  // R9
  tmo_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_ev |=> !sda_oe);

  // R12
  drive_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_i);

endmodule

bind cfg_eeprom_i2c eep_chk #(.ADDR_W(ADDR_W), .PROT_LIMIT(PROT_LIMIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe), .busy(busy),
  .dev_ack(dev_ack), .mem_we(mem_we), .mem_addr(mem_addr), .prot_on(prot_on),
  .stop_ev(stop_ev), .tmo_ev(tmo_ev)
);

// File: tb/sim_cfg_eeprom_i2c.sv
module sim_cfg_eeprom_i2c;

  localparam int Q      = 10;
  localparam int BUSY   = 2000;
  localparam int TMO    = 300;
  localparam int FREE   = 60;
  localparam int NVEC   = 8;
  localparam logic [7:0] DW = 8'hAA;   // storage, sel 101, write
  localparam logic [7:0] DR = 8'hAB;   // storage, sel 101, read
  localparam logic [7:0] PW = 8'h6A;   // latch, sel 101, write
  localparam logic [7:0] PR = 8'h6B;   // latch, sel 101, read

  // {address[8:0], data[7:0]}
  localparam logic [16:0] VEC [NVEC] = '{
    {9'd0,   8'h11}, {9'd1,   8'h22}, {9'd10,  8'h3C}, {9'd11,  8'hC5},
    {9'd383, 8'h7E}, {9'd384, 8'h81}, {9'd510, 8'h5A}, {9'd511, 8'hE7}
  };

  logic clk, rst_n, scl, sda_m;
  logic [2:0] sel;
  logic sda_oe;
  logic sda_bus;
  int n_chk, n_bad;
  logic [7:0] rbuf [3];
  logic rel_line;

  assign sda_bus = sda_m & ~sda_oe;

  cfg_eeprom_i2c #(.BUSY_CYC(BUSY), .TMO_CYC(TMO), .FREE_CYC(FREE)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sel_i(sel),
    .sda_oe(sda_oe)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    scl = 1'b0; tick(Q); sda_m = 1'b0; tick(Q);
    scl = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic end_xfer();
    bus_stop();
    tick(100);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q);
    ack = ~sda_bus;
    tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl = 1'b1; tick(Q); b[i] = sda_bus; tick(Q); scl = 1'b0;
    end
    tick(Q); sda_m = ~mack; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0;
    tick(Q); sda_m = 1'b1;
  endtask

  task automatic wr(input logic [8:0] a, input logic [7:0] d0,
                    input logic [7:0] d1, input int n, output logic ok);
    logic k0, k1, k2, k3, k4;
    bus_start();
    send_byte(DW, k0);
    send_byte({7'd0, a[8]}, k1);
    send_byte(a[7:0], k2);
    send_byte(d0, k3);
    k4 = 1'b1;
    if (n > 1) send_byte(d1, k4);
    end_xfer();
    ok = k0 & k1 & k2 & k3 & k4;
  endtask

  task automatic rd_rand(input logic [8:0] a, input int n, output logic ok);
    logic k0, k1, k2, k3;
    bus_start();
    send_byte(DW, k0);
    send_byte({7'd0, a[8]}, k1);
    send_byte(a[7:0], k2);
    bus_start();
    send_byte(DR, k3);
    for (int k = 0; k < n; k++) recv_byte(k < n - 1, rbuf[k]);
    tick(Q);
    rel_line = sda_bus;
    end_xfer();
    ok = k0 & k1 & k2 & k3;
  endtask

  task automatic rd_cur(output logic [7:0] d, output logic ok);
    bus_start();
    send_byte(DR, ok);
    recv_byte(1'b0, d);
    end_xfer();
  endtask

  task automatic prot_cmd(input logic [7:0] code, output logic ok);
    logic k0, k1;
    bus_start();
    send_byte(PW, k0);
    send_byte(code, k1);
    end_xfer();
    ok = k0 & k1;
  endtask

  task automatic prot_rd(output logic [7:0] d);
    logic k0;
    bus_start();
    send_byte(PR, k0);
    recv_byte(1'b0, d);
    end_xfer();
  endtask

  task automatic probe(input logic [7:0] dev, output logic ack);
    bus_start();
    send_byte(dev, ack);
    end_xfer();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got 0x0 expected 0x1 (run finished)");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic ok, ack;
    logic [7:0] d;
    n_chk = 0; n_bad = 0;
    scl = 1'b1; sda_m = 1'b1; sel = 3'b101; rst_n = 1'b0;
    tick(5);
    rst_n = 1'b1;
    tick(10);

    // R11: no drive after reset, latch clear
    check("R11 line idle", sda_bus, 1);
    prot_rd(d);
    check("R11 latch clear", d, 8'h00);

    // R1: wrong select bits, wrong type nibble
    probe(8'hA6, ack);
    check("R1 wrong sel nack", ack, 0);
    probe(8'hCA, ack);
    check("R1 wrong type nack", ack, 0);

    // R2: table of writes, then readback
    for (int v = 0; v < NVEC; v++) begin
      wr(VEC[v][16:8], VEC[v][7:0], 8'h00, 1, ok);
      check("R2 write acked", ok, 1);
      tick(BUSY + 100);
    end
    for (int v = 0; v < NVEC; v++) begin
      rd_rand(VEC[v][16:8], 1, ok);
      check("R2 readback", rbuf[0], VEC[v][7:0]);
    end

    // R3 sequential read with wrap, R12 release after master NACK
    rd_rand(9'd510, 3, ok);
    check("R3 seq 510", rbuf[0], 8'h5A);
    check("R3 seq 511", rbuf[1], 8'hE7);
    check("R3 seq wrap 0", rbuf[2], 8'h11);
    check("R12 released after nack", rel_line, 1);

    // R4 current address read
    rd_rand(9'd10, 1, ok);
    check("R4 random 10", rbuf[0], 8'h3C);
    rd_cur(d, ok);
    check("R4 current read", d, 8'hC5);

    // R5 set latch, R8 busy nack then ack
    prot_cmd(8'h5A, ok);
    check("R5 set acked", ok, 1);
    probe(DW, ack);
    check("R8 busy nack", ack, 0);
    tick(BUSY);
    probe(DW, ack);
    check("R8 ack after busy", ack, 1);
    prot_rd(d);
    check("R5 latch reads set", d, 8'h01);

    // R6 protected writes acked but discarded, R7 upper block writable
    wr(9'd0, 8'h99, 8'h00, 1, ok);
    check("R6 protected byte acked", ok, 1);
    wr(9'd383, 8'h00, 8'h42, 2, ok);
    tick(BUSY + 100);
    rd_rand(9'd0, 1, ok);
    check("R6 addr 0 unchanged", rbuf[0], 8'h11);
    rd_rand(9'd383, 2, ok);
    check("R6 addr 383 unchanged", rbuf[0], 8'h7E);
    check("R7 addr 384 written", rbuf[1], 8'h42);

    // R5 unknown code ignored
    prot_cmd(8'h33, ok);
    check("R5 unknown code acked", ok, 1);
    prot_rd(d);
    check("R5 unknown code no effect", d, 8'h01);

    // R5 clear, then write low block
    prot_cmd(8'hA5, ok);
    tick(BUSY + 100);
    prot_rd(d);
    check("R5 latch reads clear", d, 8'h00);
    wr(9'd0, 8'h99, 8'h00, 1, ok);
    tick(BUSY + 100);
    rd_rand(9'd0, 1, ok);
    check("R5 low block writable again", rbuf[0], 8'h99);

    // R3 write wrap 511 -> 0
    wr(9'd511, 8'hA1, 8'hB2, 2, ok);
    tick(BUSY + 100);
    rd_rand(9'd511, 2, ok);
    check("R3 write at 511", rbuf[0], 8'hA1);
    check("R3 write wrapped to 0", rbuf[1], 8'hB2);

    // R9 timeout: stall SCL low while a 0 bit is driven
    bus_start();
    send_byte(DW, ack);
    send_byte(8'h00, ack);
    send_byte(8'h0A, ack);
    bus_start();
    send_byte(DR, ack);
    tick(50);
    check("R9 driving before timeout", sda_bus, 0);
    tick(TMO + 50);
    check("R9 released after timeout", sda_bus, 1);
    end_xfer();
    rd_rand(9'd11, 1, ok);
    check("R9 recovery read", rbuf[0], 8'hC5);

    // R10 START too soon after STOP
    bus_stop();
    bus_start();
    send_byte(DW, ack);
    check("R10 early start ignored", ack, 0);
    end_xfer();
    probe(DW, ack);
    check("R10 later start accepted", ack, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule